// File: doc/BRIEF.md
# Timer-Clocked Serial Port with Odd Parity

This block is a full-duplex asynchronous serial port for a small microcontroller. Software sees it as one data location: a write strobe puts a byte into the transmit holding buffer, and the read data bus always shows the last received character. The bit timing comes from a timer. A fixed divide-by-eight stage feeds a prescaler and a timer, both with programmable reload values. Each end-of-count pulse from that chain advances two independent divide-by-16 counters, one for receive and one for transmit. The bit rate is therefore clk / (8 × p × t × 16).

A mode byte controls the block. Bit 6 switches the serial function on. While it is set, the timer's end-of-count pulse drives the serial dividers and no longer raises the timer interrupt. Bit 7 selects parity mode. In that mode the eighth bit of every frame carries odd parity computed over the seven low data bits, so a frame always has 8 bits between start and stop. The receiver flags a parity mismatch and hands back a cleared eighth bit. The receive interrupt pulses when a character lands in the buffer. The transmit interrupt pulses when a stop bit has been sent in full.

Top module: `timer_uart`

## Requirements
- R1: After reset `ser_out` is 1, `sio_rdata` is 0, and `timer_irq`, `rx_irq`, `tx_irq` and `rx_perr` are 0. Whenever no frame is being sent, `ser_out` stays at 1.
- R2: With mode bit 6 clear, `timer_irq` is a one-cycle pulse repeating every 8 × `pre_val` × `tmr_val` clock cycles.
- R3: While mode bit 6 is set, `timer_irq` stays 0. Clearing the bit again brings the pulses back.
- R4: A transmitted frame is a start bit of 0, then 8 bits with the least significant bit first, then a stop bit of 1. Each bit lasts 16 end-of-count pulses.
- R5: With mode bits 7 and 6 both set, bit 7 of the sent frame is replaced by the odd parity of data bits 6:0, so that the 8 sent bits hold an odd number of ones.
- R6: `tx_irq` pulses for exactly one cycle when a stop bit has completed, and `ser_out` is 1 during that pulse.
- R7: A write made while a frame is being sent is held and goes out right after the current stop bit. The frame already on the line is not changed by the write.
- R8: The receiver starts its divide-by-16 counter at a falling edge of `ser_in` and samples each bit at count 8. When it samples the stop bit, it loads the byte and pulses `rx_irq` for one cycle. `sio_rdata` shows the byte one cycle later.
- R9: In parity mode a received character is stored with bit 7 forced to 0. `rx_perr` is 1 exactly when the 8 received bits hold an even number of ones. Outside parity mode `rx_perr` is 0.
- R10: If `ser_in` is back at 1 when the start bit is sampled at count 8, the receiver drops the start. It raises no `rx_irq`, leaves `sio_rdata` unchanged, and returns to waiting for a start bit.
- R11: A new received character replaces an unread one. `sio_rdata` shows the newest character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_val | input | 6 | Prescaler reload value p |
| tmr_val | input | 8 | Timer reload value t |
| mode_we | input | 1 | Write strobe for the mode byte |
| mode_wdata | input | 8 | Mode byte: bit 6 enables the serial function, bit 7 selects odd parity |
| sio_we | input | 1 | Write strobe for the transmit buffer |
| sio_wdata | input | 8 | Byte to transmit |
| sio_rdata | output | 8 | Receive buffer contents (registered) |
| ser_in | input | 1 | Serial input line |
| ser_out | output | 1 | Serial output line, idles at 1 |
| timer_irq | output | 1 | Timer end-of-count interrupt pulse (serial function off only) |
| rx_irq | output | 1 | Character-received interrupt pulse |
| tx_irq | output | 1 | Transmission-complete interrupt pulse |
| rx_perr | output | 1 | Parity error flag for the last received character |

## Verification
With p = t = 1, one end-of-count pulse arrives every 8 cycles and one bit lasts 128 cycles. A byte written on one edge puts the start bit on `ser_out` at the second edge after it. The bench waits for that falling edge, then samples 64 cycles in, which is mid-bit, and every 128 cycles after that. It then allows a margin of 150 cycles for `tx_irq`. `rx_irq` arrives at the stop-bit midpoint and `sio_rdata` one cycle after it, so the bench reads the buffer two cycles after it sees the interrupt count rise. The timer period is measured as the exact number of rising edges between two pulses. Checks that something stays quiet (R3, R10) look over windows that are several times longer than the period in which the event would otherwise appear.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/tick_src.sv
module tick_src #(
  parameter int PRE_W   = 6,
  parameter int TMR_W   = 8,
  parameter int FIX_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] pre_val,
  input  logic [TMR_W-1:0] tmr_val,
  output logic             eoc
);
  localparam int FIX_W = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;

  logic [FIX_W-1:0] fix_cnt;
  logic [PRE_W-1:0] pre_cnt;
  logic [TMR_W-1:0] tmr_cnt;
  logic fix_hit, pre_hit, tmr_hit;

  // each stage advances only when the stage before it wraps
  assign fix_hit = (fix_cnt == FIX_W'(FIX_DIV - 1));
  assign pre_hit = fix_hit && (pre_cnt == pre_val - 1'b1);
  assign tmr_hit = pre_hit && (tmr_cnt == tmr_val - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_cnt <= '0;
      pre_cnt <= '0;
      tmr_cnt <= '0;
      eoc     <= 1'b0;
    end else begin
      fix_cnt <= fix_hit ? '0 : fix_cnt + 1'b1;
      if (fix_hit) pre_cnt <= pre_hit ? '0 : pre_cnt + 1'b1;
      if (pre_hit) tmr_cnt <= tmr_hit ? '0 : tmr_cnt + 1'b1;
      eoc <= tmr_hit;
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              par_en,
  input  logic              tick,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              tx_pin,
  output logic              busy,
  output logic              done
);
  localparam int FRAME = DATA_W + 2;
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(FRAME);

  logic [DATA_W-1:0] hold;
  logic              pend;
  logic [FRAME-1:0]  shreg;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;

  function automatic logic [FRAME-1:0] build(input logic [DATA_W-1:0] d, input logic p);
    logic [DATA_W-1:0] b;
    b = d;
    if (p) b[DATA_W-1] = ~^d[DATA_W-2:0];
    return {1'b1, b, 1'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= '0;
      pend   <= 1'b0;
      shreg  <= '1;
      cnt    <= '0;
      idx    <= '0;
      tx_pin <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        busy   <= 1'b0;
        tx_pin <= 1'b1;
      end else if (!busy) begin
        tx_pin <= 1'b1;
        if (pend) begin
          shreg  <= build(hold, par_en) >> 1;
          tx_pin <= 1'b0;
          busy   <= 1'b1;
          cnt    <= '0;
          idx    <= '0;
          pend   <= 1'b0;
        end
      end else if (tick) begin
        if (cnt == CNT_W'(OVS - 1)) begin
          cnt <= '0;
          if (idx == IDX_W'(FRAME - 1)) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            tx_pin <= 1'b1;
          end else begin
            idx    <= idx + 1'b1;
            tx_pin <= shreg[0];
            shreg  <= {1'b1, shreg[FRAME-1:1]};
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      // a write wins over the launch clear in the same cycle
      if (wr) begin
        hold <= wdata;
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              par_en,
  input  logic              tick,
  input  logic              rx_in,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              done
);
  localparam int CNT_W = $clog2(OVS);
  localparam int MID   = OVS / 2;
  localparam int IDX_W = $clog2(DATA_W);

  rx_state_t         state;
  logic              s1, s2, prev;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              mid_hit;

  assign mid_hit = tick && (cnt == CNT_W'(MID - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      s1    <= 1'b1;
      s2    <= 1'b1;
      prev  <= 1'b1;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      data  <= '0;
      perr  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      s1   <= rx_in;
      s2   <= s1;
      prev <= s2;
      if (tick) cnt <= (cnt == CNT_W'(OVS - 1)) ? '0 : cnt + 1'b1;
      if (!en) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: begin
            if (prev && !s2) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (mid_hit) begin
              state <= s2 ? RX_IDLE : RX_DATA;
              idx   <= '0;
            end
          end
          RX_DATA: begin
            if (mid_hit) begin
              shreg <= {s2, shreg[DATA_W-1:1]};
              idx   <= idx + 1'b1;
              if (idx == IDX_W'(DATA_W - 1)) state <= RX_STOP;
            end
          end
          default: begin
            if (mid_hit) begin
              state <= RX_IDLE;
              done  <= 1'b1;
              if (par_en) begin
                data <= {1'b0, shreg[DATA_W-2:0]};
                perr <= ~^shreg;
              end else begin
                data <= shreg;
                perr <= 1'b0;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/timer_uart.sv
module timer_uart #(
  parameter int PRE_W   = 6,
  parameter int TMR_W   = 8,
  parameter int DATA_W  = 8,
  parameter int OVS     = 16,
  parameter int MODE_W  = 8,
  parameter int EN_BIT  = 6,
  parameter int PAR_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PRE_W-1:0]  pre_val,
  input  logic [TMR_W-1:0]  tmr_val,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              sio_we,
  input  logic [DATA_W-1:0] sio_wdata,
  output logic [DATA_W-1:0] sio_rdata,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              timer_irq,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic              rx_perr
);
  logic              ser_en, par_en, mode_unused;
  logic              eoc, ser_tick, tx_busy;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] rdata_q;
  logic              timer_irq_q;

  assign mode_unused = ^mode_wdata;
  assign ser_tick    = eoc & ser_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_en      <= 1'b0;
      par_en      <= 1'b0;
      timer_irq_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (mode_we) begin
        ser_en <= mode_wdata[EN_BIT];
        par_en <= mode_wdata[PAR_BIT];
      end
      timer_irq_q <= eoc & ~ser_en;
      rdata_q     <= rx_byte;
    end
  end

  tick_src #(.PRE_W(PRE_W), .TMR_W(TMR_W), .FIX_DIV(8)) u_tick (
    .clk(clk), .rst(rst), .pre_val(pre_val), .tmr_val(tmr_val), .eoc(eoc)
  );

  uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .en(ser_en), .par_en(par_en), .tick(ser_tick),
    .wr(sio_we), .wdata(sio_wdata), .tx_pin(ser_out), .busy(tx_busy), .done(tx_irq)
  );

  uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .en(ser_en), .par_en(par_en), .tick(ser_tick),
    .rx_in(ser_in), .data(rx_byte), .perr(rx_perr), .done(rx_irq)
  );

  assign sio_rdata = rdata_q;
  assign timer_irq = timer_irq_q;
endmodule

// File: rtl/timer_uart_chk.sv
module timer_uart_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_en,
  input logic              par_en,
  input logic              tx_busy,
  input logic              ser_out,
  input logic              timer_irq,
  input logic              tx_irq,
  input logic              rx_irq,
  input logic              rx_perr,
  input logic [DATA_W-1:0] rx_byte
);
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> ser_out);

  assert_timer_single_R2: assert property (@(posedge clk) disable iff (rst)
    timer_irq |=> !timer_irq);

  assert_timer_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (ser_en && $past(ser_en)) |-> !timer_irq);

  assert_tx_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);

  assert_tx_done_mark_R6: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> ser_out);

  assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  assert_rx_bit7_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && par_en && $past(par_en)) |-> !rx_byte[DATA_W-1]);

  assert_no_perr_plain_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && !par_en && !$past(par_en)) |-> !rx_perr);
endmodule

bind timer_uart timer_uart_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ser_en(ser_en), .par_en(par_en), .tx_busy(tx_busy),
  .ser_out(ser_out), .timer_irq(timer_irq), .tx_irq(tx_irq), .rx_irq(rx_irq),
  .rx_perr(rx_perr), .rx_byte(rx_byte)
);

// File: tb/sim_timer_uart.sv
module sim_timer_uart;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [5:0] pre_val = 6'd2;
  logic [7:0] tmr_val = 8'd3;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic       sio_we = 1'b0;
  logic [7:0] sio_wdata = '0;
  logic [7:0] sio_rdata;
  logic       ser_out, timer_irq, rx_irq, tx_irq, rx_perr;
  logic       loop = 1'b0, drv = 1'b1;
  logic       ser_in;
  assign ser_in = loop ? ser_out : drv;

  timer_uart u0 (
    .clk(clk), .rst(rst), .pre_val(pre_val), .tmr_val(tmr_val),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .sio_we(sio_we),
    .sio_wdata(sio_wdata), .sio_rdata(sio_rdata), .ser_in(ser_in),
    .ser_out(ser_out), .timer_irq(timer_irq), .rx_irq(rx_irq),
    .tx_irq(tx_irq), .rx_perr(rx_perr)
  );

  int checks = 0, errors = 0;
  int tmr_n = 0, rx_n = 0, tx_n = 0;
  longint cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (timer_irq) tmr_n++;
    if (rx_irq) rx_n++;
    if (tx_irq) tx_n++;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); mode_we = 1'b1; mode_wdata = v;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); sio_we = 1'b1; sio_wdata = v;
    @(negedge clk); sio_we = 1'b0;
  endtask

  task automatic capture(output logic [7:0] d, output logic st, output logic sp);
    int t = 0;
    d = '0;
    while (ser_out !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    repeat (64) @(negedge clk);
    st = ser_out;
    for (int i = 0; i < 8; i++) begin
      repeat (128) @(negedge clk);
      d[i] = ser_out;
    end
    repeat (128) @(negedge clk);
    sp = ser_out;
  endtask

  task automatic drive_frame(input logic [7:0] b);
    @(negedge clk); drv = 1'b0;
    repeat (128) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv = b[i];
      repeat (128) @(negedge clk);
    end
    drv = 1'b1;
    repeat (128) @(negedge clk);
  endtask

  task automatic wait_rx(input int base);
    int t = 0;
    while (rx_n == base && t < 3000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_timer_pulse;
    int t = 0;
    @(negedge clk);
    while (!timer_irq && t < 500) begin @(negedge clk); t++; end
  endtask

  // R1: reset state
  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ser_out idle", ser_out, 1);
    chk("R1", "sio_rdata", sio_rdata, 0);
    chk("R1", "irqs and perr", {timer_irq, rx_irq, tx_irq, rx_perr}, 0);
  endtask

  // R2: timer period 8*p*t with serial off
  task automatic t_timer;
    longint a;
    wait_timer_pulse();
    a = cyc;
    wait_timer_pulse();
    chk("R2", "period p=2 t=3", cyc - a, 48);
    rst = 1'b1; pre_val = 6'd1; tmr_val = 8'd1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_timer_pulse();
    a = cyc;
    wait_timer_pulse();
    chk("R2", "period p=1 t=1", cyc - a, 8);
  endtask

  // R3: enable takes the timer interrupt away
  task automatic t_quiet;
    int n0;
    wr_mode(8'h40);
    repeat (4) @(negedge clk);
    n0 = tmr_n;
    repeat (200) @(negedge clk);
    chk("R3", "no timer_irq while enabled", tmr_n - n0, 0);
    wr_mode(8'h00);
    n0 = tmr_n;
    repeat (100) @(negedge clk);
    chk("R3", "timer_irq back when disabled", (tmr_n - n0) >= 11, 1);
    wr_mode(8'h40);
  endtask

  // R4, R6: plain frame
  task automatic t_tx_plain;
    logic [7:0] d; logic st, sp; int n0;
    n0 = tx_n;
    wr_data(8'hA5);
    capture(d, st, sp);
    chk("R4", "start bit", st, 0);
    chk("R4", "data A5", d, 8'hA5);
    chk("R4", "stop bit", sp, 1);
    repeat (150) @(negedge clk);
    chk("R6", "one tx_irq", tx_n - n0, 1);
  endtask

  // R5: odd parity replaces bit 7
  task automatic t_tx_parity;
    logic [7:0] d; logic st, sp;
    wr_mode(8'hC0);
    wr_data(8'h03);
    capture(d, st, sp);
    chk("R5", "parity of 03", d, 8'h83);
    wr_data(8'h87);
    capture(d, st, sp);
    chk("R5", "parity of 87", d, 8'h07);
    repeat (150) @(negedge clk);
  endtask

  // R7: write while busy is queued
  task automatic t_tx_queue;
    logic [7:0] d; logic st, sp; int n0;
    wr_mode(8'h40);
    n0 = tx_n;
    wr_data(8'h11);
    repeat (20) @(negedge clk);
    wr_data(8'hE2);
    capture(d, st, sp);
    chk("R7", "first frame untouched", d, 8'h11);
    capture(d, st, sp);
    chk("R7", "queued frame", d, 8'hE2);
    chk("R7", "queued stop", sp, 1);
    repeat (150) @(negedge clk);
    chk("R7", "two tx_irq", tx_n - n0, 2);
  endtask

  // R8: loopback receive
  task automatic t_rx_loop;
    int n0;
    loop = 1'b1;
    n0 = rx_n;
    wr_data(8'h5A);
    wait_rx(n0);
    chk("R8", "rx count", rx_n - n0, 1);
    chk("R8", "rx data 5A", sio_rdata, 8'h5A);
    chk("R8", "no perr plain", rx_perr, 0);
    repeat (200) @(negedge clk);
    loop = 1'b0;
  endtask

  // R9: parity check on receive
  task automatic t_rx_parity;
    wr_mode(8'hC0);
    drive_frame(8'h93);
    repeat (4) @(negedge clk);
    chk("R9", "bit7 cleared", sio_rdata, 8'h13);
    chk("R9", "perr on even ones", rx_perr, 1);
    drive_frame(8'h13);
    repeat (4) @(negedge clk);
    chk("R9", "data good parity", sio_rdata, 8'h13);
    chk("R9", "perr clear on odd ones", rx_perr, 0);
  endtask

  // R10: false start
  task automatic t_false_start;
    int n0; logic [7:0] r0;
    wr_mode(8'h40);
    n0 = rx_n;
    r0 = sio_rdata;
    @(negedge clk); drv = 1'b0;
    repeat (30) @(negedge clk);
    drv = 1'b1;
    repeat (400) @(negedge clk);
    chk("R10", "no rx_irq", rx_n - n0, 0);
    chk("R10", "buffer unchanged", sio_rdata, r0);
    drive_frame(8'h3C);
    repeat (4) @(negedge clk);
    chk("R10", "recovers for next frame", sio_rdata, 8'h3C);
  endtask

  // R11: overwrite
  task automatic t_overwrite;
    int n0;
    n0 = rx_n;
    drive_frame(8'h11);
    drive_frame(8'h22);
    repeat (4) @(negedge clk);
    chk("R11", "two characters", rx_n - n0, 2);
    chk("R11", "newest kept", sio_rdata, 8'h22);
  endtask

  initial begin
    t_reset();
    t_timer();
    t_quiet();
    t_tx_plain();
    t_tx_parity();
    t_tx_queue();
    t_rx_loop();
    t_rx_parity();
    t_false_start();
    t_overwrite();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule